// File: doc/BRIEF.md
# PHY Serial Test Port Access Sequencer

This block is a hardware master for the byte-wide serial test port found on many mixed-signal PHYs. A requester asks for one register access at a time through a valid/ready request interface carrying a write flag, an address and write data. The sequencer turns that request into timed pin activity on the port. The enable level tells the PHY which phase is in progress: the address is clocked in while enable is high. A write then clocks the data byte in after enable has dropped. A read instead waits a settle interval and samples the separate data-out bus.

Every clock level and every drive-before-clock setup interval lasts a programmable number of system clocks, called the half period. A separate clear command runs the low-high-low clear pulse that must come before any access. The request fields are wider than the port, so a requester can present an out-of-range value. Such a request is refused with an error flag and causes no pin activity. Each accepted request, refused request and clear command ends with a one-cycle done strobe.

Top module: `phy_tport_seq`

## Requirements
- R1: After reset, req_ready is 1 and done, err, rd_data, tp_clr, tp_clk, tp_en and tp_din are all 0.
- R2: A write with half period N, accepted at edge k, drives tp_en=1 with tp_din=address for 3N cycles, with tp_clk=1 only during the middle N of them. It then drives tp_en=0 with tp_din=data for 3N cycles, again with tp_clk=1 only during the middle N. done=1 follows in the cycle after edge k+6N.
- R3: A read drives the same 3N-cycle address phase as a write. It then holds tp_en=0, tp_clk=0 and tp_din=0 for S settle cycles. tp_dout is captured into rd_data at the edge that ends the settle interval, and done=1 is shown in the cycle after that edge. rd_data holds its value until the next read.
- R4: A half_period value of 0 behaves as 1.
- R5: A settle_cycles value of 0 selects the default settle count SETTLE_DEF, which is 125 cycles by default (1 us at 125 MHz). Any other value is the settle count itself.
- R6: A request is refused when its address exceeds 0xFF, or when it is a write and its data exceeds 0xFF. A read ignores its data field. A refused request produces done=1 and err=1 in the cycle after acceptance and drives no port pin. err is 0 with every other done.
- R7: A clear command with half period N drives tp_clr low for N cycles, high for N cycles and low for N cycles, with tp_en and tp_clk held at 0. done follows after the 3N cycles. When clr_req and req_valid are both high in an idle cycle, the clear runs and the request is not taken.
- R8: req_ready is 0 from acceptance until the done strobe and returns to 1 in the cycle after it. Requests and clear commands presented while busy have no effect.
- R9: While idle, tp_clk, tp_en and tp_clr are 0.
- R10: half_period and settle_cycles are sampled when a request is accepted. Changes made during an access do not alter its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REQ_W | Requested register address |
| req_wdata | input | REQ_W | Requested write data |
| clr_req | input | 1 | Run a port clear pulse |
| half_period | input | PW_W | Cycles per clock level and setup interval (0 means 1) |
| settle_cycles | input | SET_W | Read settle cycles (0 means SETTLE_DEF) |
| req_ready | output | 1 | Idle, able to accept |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Request refused, valid with done |
| rd_data | output | PORT_W | Last captured read byte |
| tp_clr | output | 1 | Test port clear |
| tp_clk | output | 1 | Test port clock |
| tp_en | output | 1 | Test port enable (high in the address phase) |
| tp_din | output | PORT_W | Test port data in |
| tp_dout | input | PORT_W | Test port data out |

## Verification
Taking the acceptance edge as cycle 0, the pins follow a fixed schedule. Pin state for cycle c belongs to phase (c-1)/N. done falls at cycle 6N+1 for a write, 3N+S+1 for a read, 3N+1 for a clear and 1 for a refused request, and req_ready returns one cycle later. The bench samples every cycle at the falling edge and compares each sample with a schedule it computes from the effective N and S. It presents the true read byte on tp_dout only from the last settle cycle onward, and shows a different byte before that. It keeps a bait request asserted while the block is busy and changes the timing inputs mid-access, so that early capture, late capture, unwanted restarts and use of unlatched settings all show up as mismatches.

// File: rtl/phy_tport_pkg.sv
package phy_tport_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ASET,
      ST_AHI,
      ST_ALO,
      ST_DSET,
      ST_DHI,
      ST_DLO,
      ST_RWAIT,
      ST_CLO1,
      ST_CHI,
      ST_CLO2,
      ST_DONE
   } tport_state_e;

   function automatic logic is_addr_phase(tport_state_e s);
      return (s == ST_ASET) || (s == ST_AHI) || (s == ST_ALO);
   endfunction

   function automatic logic is_data_phase(tport_state_e s);
      return (s == ST_DSET) || (s == ST_DHI) || (s == ST_DLO);
   endfunction

endpackage

// File: rtl/tport_req_screen.sv
module tport_req_screen #(
   parameter int REQ_W  = 12,
   parameter int PORT_W = 8
) (
   input  logic [REQ_W-1:0]  addr_in,
   input  logic [REQ_W-1:0]  data_in,
   input  logic              write_in,
   output logic              in_range,
   output logic [PORT_W-1:0] addr_out,
   output logic [PORT_W-1:0] data_out
);

   if (REQ_W < PORT_W) begin : g_bad_width
      $error("tport_req_screen: REQ_W must not be narrower than PORT_W");
   end

   if (REQ_W > PORT_W) begin : g_range_check
      logic addr_hi;
      logic data_hi;
      assign addr_hi  = |addr_in[REQ_W-1:PORT_W];
      assign data_hi  = |data_in[REQ_W-1:PORT_W];
      assign in_range = !addr_hi && !(write_in && data_hi);
   end else begin : g_no_check
      assign in_range = 1'b1;
   end

   assign addr_out = addr_in[PORT_W-1:0];
   assign data_out = data_in[PORT_W-1:0];

endmodule

// File: rtl/tport_phase_timer.sv
module tport_phase_timer #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   if (CW < 1) begin : g_bad_cw
      $error("tport_phase_timer: CW must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/phy_tport_seq.sv
module phy_tport_seq
   import phy_tport_pkg::*;
#(
   parameter int REQ_W      = 12,
   parameter int PORT_W     = 8,
   parameter int PW_W       = 8,
   parameter int SET_W      = 12,
   parameter int SETTLE_DEF = 125
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [REQ_W-1:0]  req_addr,
   input  logic [REQ_W-1:0]  req_wdata,
   input  logic              clr_req,
   input  logic [PW_W-1:0]   half_period,
   input  logic [SET_W-1:0]  settle_cycles,
   output logic              req_ready,
   output logic              done,
   output logic              err,
   output logic [PORT_W-1:0] rd_data,
   output logic              tp_clr,
   output logic              tp_clk,
   output logic              tp_en,
   output logic [PORT_W-1:0] tp_din,
   input  logic [PORT_W-1:0] tp_dout
);

   localparam int CW = (PW_W > SET_W) ? PW_W : SET_W;
   localparam logic [SET_W-1:0] SDEF_M1 = SET_W'(SETTLE_DEF - 1);

   if (SETTLE_DEF < 1 || SETTLE_DEF > (2 ** SET_W)) begin : g_bad_settle
      $error("phy_tport_seq: SETTLE_DEF must be in 1 .. 2**SET_W");
   end
   if (PW_W < 1 || SET_W < 1 || PORT_W < 1) begin : g_bad_widths
      $error("phy_tport_seq: widths must be at least 1");
   end

   tport_state_e state, state_nxt;

   logic              scr_ok;
   logic [PORT_W-1:0] scr_addr, scr_data;
   logic [PORT_W-1:0] addr_q, data_q;
   logic              wr_q;
   logic [PW_W-1:0]   half_m1_live, half_m1_q;
   logic [SET_W-1:0]  settle_m1_live, settle_m1_q;
   logic              tmr_load, tmr_last;
   logic [CW-1:0]     tmr_val;
   logic              accept, reject, start_clr, capture;

   tport_req_screen #(.REQ_W(REQ_W), .PORT_W(PORT_W)) i_screen (
      .addr_in  (req_addr),
      .data_in  (req_wdata),
      .write_in (req_write),
      .in_range (scr_ok),
      .addr_out (scr_addr),
      .data_out (scr_data)
   );

   tport_phase_timer #(.CW(CW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   assign half_m1_live   = (half_period == '0) ? '0 : half_period - 1'b1;
   assign settle_m1_live = (settle_cycles == '0) ? SDEF_M1 : settle_cycles - 1'b1;

   assign req_ready = (state == ST_IDLE);
   assign start_clr = req_ready && clr_req;
   assign accept    = req_ready && !clr_req && req_valid && scr_ok;
   assign reject    = req_ready && !clr_req && req_valid && !scr_ok;

   always_comb begin
      state_nxt = state;
      tmr_load  = 1'b0;
      tmr_val   = CW'(half_m1_q);
      capture   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            tmr_val = CW'(half_m1_live);
            if (start_clr) begin
               state_nxt = ST_CLO1;
               tmr_load  = 1'b1;
            end else if (accept) begin
               state_nxt = ST_ASET;
               tmr_load  = 1'b1;
            end else if (reject) begin
               state_nxt = ST_DONE;
            end
         end
         ST_ASET: if (tmr_last) begin state_nxt = ST_AHI; tmr_load = 1'b1; end
         ST_AHI:  if (tmr_last) begin state_nxt = ST_ALO; tmr_load = 1'b1; end
         ST_ALO: begin
            if (tmr_last) begin
               tmr_load = 1'b1;
               if (wr_q) begin
                  state_nxt = ST_DSET;
               end else begin
                  state_nxt = ST_RWAIT;
                  tmr_val   = CW'(settle_m1_q);
               end
            end
         end
         ST_DSET: if (tmr_last) begin state_nxt = ST_DHI; tmr_load = 1'b1; end
         ST_DHI:  if (tmr_last) begin state_nxt = ST_DLO; tmr_load = 1'b1; end
         ST_DLO:  if (tmr_last) state_nxt = ST_DONE;
         ST_RWAIT: begin
            if (tmr_last) begin
               state_nxt = ST_DONE;
               capture   = 1'b1;
            end
         end
         ST_CLO1: if (tmr_last) begin state_nxt = ST_CHI; tmr_load = 1'b1; end
         ST_CHI:  if (tmr_last) begin state_nxt = ST_CLO2; tmr_load = 1'b1; end
         ST_CLO2: if (tmr_last) state_nxt = ST_DONE;
         ST_DONE: state_nxt = ST_IDLE;
         default: state_nxt = ST_IDLE;
      endcase
   end

   // Request context, latched once at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q      <= '0;
         data_q      <= '0;
         wr_q        <= 1'b0;
         half_m1_q   <= '0;
         settle_m1_q <= '0;
      end else if (accept || start_clr) begin
         addr_q      <= scr_addr;
         data_q      <= scr_data;
         wr_q        <= req_write;
         half_m1_q   <= half_m1_live;
         settle_m1_q <= settle_m1_live;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         state <= state_nxt;
      end
   end

   // Port pins registered from the next state so they line up with it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tp_en  <= 1'b0;
         tp_clk <= 1'b0;
         tp_clr <= 1'b0;
         tp_din <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         tp_en  <= is_addr_phase(state_nxt);
         tp_clk <= (state_nxt == ST_AHI) || (state_nxt == ST_DHI);
         tp_clr <= (state_nxt == ST_CHI);
         if (is_addr_phase(state_nxt)) begin
            tp_din <= (state == ST_IDLE) ? scr_addr : addr_q;
         end else if (is_data_phase(state_nxt)) begin
            tp_din <= data_q;
         end else begin
            tp_din <= '0;
         end
         done   <= (state_nxt == ST_DONE);
         err    <= reject;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (capture) begin
         rd_data <= tp_dout;
      end
   end

   // R9: no pin activity while idle
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!tp_clk && !tp_en && !tp_clr));

   // R8: done only while busy, ready returns right after it
   a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);
   a_r8_done_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready);

   // R6: err only accompanies done
   a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   // R7: clear pulse never overlaps clock or enable
   a_r7_clr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      tp_clr |-> (!tp_en && !tp_clk));

   // R2: data-in holds while the test clock is high
   a_r2_din_stable_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (tp_clk && $past(tp_clk)) |-> $stable(tp_din));

   // R2: enable drops only with the test clock low
   a_r2_en_fall_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tp_en) |-> !tp_clk);

endmodule

// File: tb/test_phy_tport_seq.sv
module test_phy_tport_seq;

   localparam int REQ_W  = 12;
   localparam int PORT_W = 8;
   localparam int PW_W   = 8;
   localparam int SET_W  = 12;
   localparam int SDEF   = 125;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [REQ_W-1:0]  req_addr = '0;
   logic [REQ_W-1:0]  req_wdata = '0;
   logic              clr_req = 1'b0;
   logic [PW_W-1:0]   half_period = 8'd1;
   logic [SET_W-1:0]  settle_cycles = 12'd1;
   logic              req_ready, done, err, tp_clr, tp_clk, tp_en;
   logic [PORT_W-1:0] rd_data, tp_din;
   logic [PORT_W-1:0] tp_dout = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   phy_tport_seq #(.REQ_W(REQ_W), .PORT_W(PORT_W), .PW_W(PW_W), .SET_W(SET_W),
                   .SETTLE_DEF(SDEF)) i_phy_tport_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .clr_req(clr_req),
      .half_period(half_period), .settle_cycles(settle_cycles),
      .req_ready(req_ready), .done(done), .err(err), .rd_data(rd_data),
      .tp_clr(tp_clr), .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din),
      .tp_dout(tp_dout)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // Expected {clr, en, clk, din} for cycle c after acceptance; kind 0 write, 1 read, 2 clear
   function automatic logic [10:0] exp_pins(input int kind, input int c, input int n,
                                            input logic [7:0] a, input logic [7:0] d);
      int p;
      p = (c - 1) / n;
      if (kind == 2) return {(p == 1), 1'b0, 1'b0, 8'h00};
      if (p < 3) return {1'b0, 1'b1, (p == 1), a};
      if (kind == 0 && p < 6) return {1'b0, 1'b0, (p == 4), d};
      return 11'd0;
   endfunction

   task automatic run(input int kind, input int addr, input int data, input int half,
                      input int set, input bit also_valid, input logic [7:0] dout);
      int n, s, last, first_bad_c;
      bit bad;
      string tag;
      logic [10:0] exp, act, first_exp, first_act;
      bit ready_low_ok, done_early;
      logic [7:0] rd_keep;
      n = (half == 0) ? 1 : half;                       // R4
      s = (set == 0) ? SDEF : set;                      // R5
      bad = (kind != 2) && (addr > 255 || (kind == 0 && data > 255));
      if (bad) last = 1;
      else if (kind == 0) last = 6 * n + 1;
      else if (kind == 1) last = 3 * n + s + 1;
      else last = 3 * n + 1;
      tag = bad ? "R6" : (kind == 0) ? "R2 R4 R10" : (kind == 1) ? "R3 R5 R10" : "R7";
      first_bad_c = 0; first_exp = '0; first_act = '0;
      ready_low_ok = 1'b1; done_early = 1'b0;
      @(negedge clk);
      half_period   = PW_W'(half);
      settle_cycles = SET_W'(set);
      tp_dout       = ~dout;
      req_addr      = REQ_W'(addr);
      req_wdata     = REQ_W'(data);
      req_write     = (kind == 0);
      clr_req       = (kind == 2);
      req_valid     = (kind != 2) || also_valid;
      for (int c = 1; c <= last; c++) begin
         @(negedge clk);
         exp = bad ? 11'd0 : exp_pins(kind, c, n, addr[7:0], data[7:0]);
         act = {tp_clr, tp_en, tp_clk, tp_din};
         if (act != exp && first_bad_c == 0) begin
            first_bad_c = c; first_exp = exp; first_act = act;
         end
         if (req_ready) ready_low_ok = 1'b0;
         if (c < last && done) done_early = 1'b1;
         if (c == last) begin
            req_valid = 1'b0;
            chk(done == 1'b1, tag, "done at due cycle", int'(done), 1);
            chk(err == bad, "R6", "err with done", int'(err), int'(bad));
            if (kind == 1 && !bad)
               chk(rd_data == dout, "R3", "captured read data", int'(rd_data), int'(dout));
            rd_keep = rd_data;
            tp_dout = dout ^ 8'h3C;
         end else begin
            if (c == 1) begin                           // R8 bait while busy
               clr_req   = 1'b0;
               req_valid = 1'b1;
               req_write = 1'($urandom);
               req_addr  = REQ_W'($urandom % 256);
               req_wdata = REQ_W'($urandom % 256);
            end
            if (c == 2) begin                           // R10 config change mid-access
               half_period   = PW_W'($urandom % 6);
               settle_cycles = SET_W'($urandom % 9);
            end
            if (kind == 1 && c == 3 * n + s) tp_dout = dout;
         end
      end
      chk(first_bad_c == 0, tag, $sformatf("pin schedule at cycle %0d", first_bad_c),
          int'(first_act), int'(first_exp));
      chk(ready_low_ok && !done_early, "R8", "ready low and no early done while busy",
          int'({ready_low_ok, done_early}), 2);
      @(negedge clk);
      chk(req_ready && !done && !tp_clk && !tp_en && !tp_clr, "R8 R9",
          "idle after done {ready,done,clk,en,clr}",
          int'({req_ready, done, tp_clk, tp_en, tp_clr}), 5'b10000);
      if (kind == 1 && !bad)
         chk(rd_data == rd_keep, "R3", "rd_data holds after done", int'(rd_data), int'(rd_keep));
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !done && !err, "R1", "reset {ready,done,err}",
          int'({req_ready, done, err}), 3'b100);
      chk({tp_clr, tp_en, tp_clk, tp_din, rd_data} == '0, "R1", "reset pins and rd_data",
          int'({tp_clr, tp_en, tp_clk, tp_din, rd_data}), 0);

      run(2, 0, 0, 2, 1, 1'b0, 8'h00);         // R7 clear before access
      run(0, 'h3C, 'hA5, 1, 1, 1'b0, 8'h00);   // R2 minimum width
      run(0, 'hC3, 'h5A, 3, 1, 1'b0, 8'h00);   // R2 wider pulses
      run(0, 'hFF, 'h00, 0, 1, 1'b0, 8'h00);   // R4 half period 0
      run(1, 'h12, 0, 2, 5, 1'b0, 8'h5A);      // R3 short settle
      run(1, 'h80, 0, 0, 0, 1'b0, 8'hE7);      // R4 R5 default settle
      run(0, 'h100, 'h11, 2, 1, 1'b0, 8'h00);  // R6 address too large
      run(0, 'h22, 'h1FF, 2, 1, 1'b0, 8'h00);  // R6 write data too large
      run(1, 'h33, 'h1FF, 1, 2, 1'b0, 8'h96);  // R6 read ignores data field
      run(2, 'h44, 'h55, 1, 1, 1'b1, 8'h00);   // R7 clear wins over request

      for (int i = 0; i < 40; i++) begin
         int kind, addr, data, half, set;
         kind = int'($urandom % 3);
         addr = ($urandom % 8 == 0) ? int'(256 + $urandom % 3000) : int'($urandom % 256);
         data = ($urandom % 8 == 0) ? int'(256 + $urandom % 3000) : int'($urandom % 256);
         half = int'($urandom % 5);
         set  = ($urandom % 10 == 0) ? 0 : int'(1 + $urandom % 10);
         run(kind, addr, data, half, set, 1'($urandom), 8'($urandom));
      end

      summary();
      $finish;
   end

endmodule